// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital sequencer for one half-bridge of a synchronous buck converter. Each clock it takes a pre-decoded three-level switching command, a pre-decoded three-level enable command and a supply-good flag. From these it produces enables for the high-side and low-side gate drivers. Between the two gates it inserts an adaptive dead time: it waits for a sense bit that reports the opposite gate as off, for at least a minimum number of cycles, and a timeout bounds the wait. A mid-level switching command starts a light-load diode-emulation cycle. The high side drops, the low side turns on after the dead time, and a blanking window runs during which the zero-cross comparator is ignored. After the window the low side is released on the first zero-cross indication.

A mid-level enable brakes the channel by holding both gates low, so the inductor current flows through the low-side body diode. A low enable turns the channel off. A false supply-good flag overrides everything else. There is no streaming data path: every pin is a plain control or status level that is sampled or updated once per clock. A 4-bit phase code tells surrounding logic which step of the sequence is active.

Top module: `buck_gate_seq`

## Requirements
- R1: Level codes on `pwm_code` and `en_code` are 2'b00 low, 2'b01 mid and 2'b10 high, and 2'b11 is treated as low. `phase_code` values are 0 supply-off, 1 disabled, 2 braking, 3 wait-before-high, 4 high-side on, 5 wait-before-low, 6 low-side on, 7 wait-before-emulation, 8 blanking, 9 zero-cross watch and 10 emulation done.
- R2: A synchronous active-high `rst` puts the block in the disabled phase (code 1) with both enables low and all timers cleared.
- R3: While `supply_ok` is 0, the next clock edge sets both enables low and sets the phase to supply-off, whatever the enable and switching levels are.
- R4: With the supply good, a mid enable gives the braking phase and a low or reserved enable gives the disabled phase, both with both enables low for any switching level. Only a high enable lets the switching level steer the gates.
- R5: `hs_on` and `ls_on` are never high in the same cycle.
- R6: After a high command, `hs_on` rises at the first edge at which two conditions hold: the wait phase has lasted at least MIN_DT cycles, and `ls_off_sense` is 1. If DT_TIMEOUT cycles pass first, it rises at that point anyway. The wait phase starts at the edge that first samples the command.
- R7: After a low command, `ls_on` rises under the same rule, using `hs_off_sense`.
- R8: A mid command clears `hs_on` at the next edge, and `ls_on` then rises after the R7 dead time. If the low side is already on, the block goes straight to blanking and `ls_on` stays high.
- R9: Blanking lasts BLANK_CYC edges after the low side enters it, and `zc_det` has no effect during that time.
- R10: After blanking, the first edge that samples `zc_det` = 1 clears `ls_on`. It stays low while the command remains mid, even if `zc_det` returns to 0.
- R11: A high or low command resets the zero-cross sequence. From blanking or watch, a low command holds the low side on and re-arms blanking for the next mid command. From any emulation phase, a high command goes through the dead time to the high side.
- R12: If the command changes during a dead-time wait, the wait restarts toward the new target at the next edge.
- R13: `phase_code` shows the registered phase in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Supply above its lockout threshold |
| en_code | input | 2 | Pre-decoded enable level (R1 encoding) |
| pwm_code | input | 2 | Pre-decoded switching command level (R1 encoding) |
| zc_det | input | 1 | Zero-cross comparator: inductor current at or below zero |
| hs_off_sense | input | 1 | High-side gate reported off |
| ls_off_sense | input | 1 | Low-side gate reported off |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| phase_code | output | 4 | Current sequencer phase (R1 encoding) |

## Verification
The bench runs every combination of supply flag, enable level and switching level from reset, including the reserved codes. This separates the override order of lockout, braking and disable, and shows which gate each steady command leaves on. Two dead-time sweeps move the release of the opposite-gate sense across the whole window, from before the minimum to past the timeout. They show whether the minimum, the sense bit and the timeout each win in their own range. A zero-cross sweep moves the comparator assertion from before blanking to after it, to show that blanking masks the comparator and that the later watch honours it. Directed sequences then cover a command change during the dead-time wait, mid entered from each gate, and zero-cross reset by high and low commands.

// File: rtl/buck_gate_seq_pkg.sv
package buck_gate_seq_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSVD = 2'b11
  } level_e;

  typedef enum logic [3:0] {
    PH_SUPPLY_OFF = 4'd0,
    PH_DISABLED   = 4'd1,
    PH_BRAKE      = 4'd2,
    PH_WAIT_HS    = 4'd3,
    PH_HS_ON      = 4'd4,
    PH_WAIT_LS    = 4'd5,
    PH_LS_ON      = 4'd6,
    PH_WAIT_EMU   = 4'd7,
    PH_BLANK      = 4'd8,
    PH_WATCH      = 4'd9,
    PH_EMU_DONE   = 4'd10
  } phase_e;

  // Reserved code folds onto low so an undefined command never drives the high side.
  function automatic level_e fold_level(input logic [1:0] code);
    case (code)
      2'b01:   return LVL_MID;
      2'b10:   return LVL_HIGH;
      default: return LVL_LOW;
    endcase
  endfunction

  // Dead-time phase that leads toward the gate a command selects.
  function automatic phase_e wait_for(input level_e lvl);
    case (lvl)
      LVL_HIGH: return PH_WAIT_HS;
      LVL_MID:  return PH_WAIT_EMU;
      default:  return PH_WAIT_LS;
    endcase
  endfunction

endpackage

// File: rtl/buck_gate_seq_timer.sv
module buck_gate_seq_timer #(
  parameter int W   = 4,
  parameter int SAT = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT_V = W'(SAT);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt <= '0;
    end else if (cnt != SAT_V) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/buck_gate_seq_deadtime.sv
module buck_gate_seq_deadtime #(
  parameter int MIN_DT     = 3,
  parameter int DT_TIMEOUT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic opp_off,
  output logic done
);
  localparam int CW = (DT_TIMEOUT < 2) ? 1 : $clog2(DT_TIMEOUT + 1);

  logic [CW-1:0] cnt;
  logic [CW:0]   elapsed;
  logic          min_met;
  logic          limit_hit;

  buck_gate_seq_timer #(.W(CW), .SAT(DT_TIMEOUT)) dt_timer_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (restart),
    .cnt     (cnt)
  );

  // elapsed counts the cycle being evaluated now.
  assign elapsed   = {1'b0, cnt} + (CW + 1)'(1);
  assign min_met   = elapsed >= (CW + 1)'(MIN_DT);
  assign limit_hit = elapsed >= (CW + 1)'(DT_TIMEOUT);
  assign done      = run && ((min_met && opp_off) || limit_hit);

  initial begin
    if (MIN_DT < 1 || DT_TIMEOUT < MIN_DT) $error("dead-time parameters out of range");
  end
endmodule

// File: rtl/buck_gate_seq_blanking.sv
module buck_gate_seq_blanking #(
  parameter int BLANK_CYC = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);

  logic [BW-1:0] cnt;

  buck_gate_seq_timer #(.W(BW), .SAT(BLANK_CYC - 1)) blank_timer_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (restart),
    .cnt     (cnt)
  );

  assign expired = run && (cnt == BW'(BLANK_CYC - 1));

  initial begin
    if (BLANK_CYC < 1) $error("blanking length must be at least one cycle");
  end
endmodule

// File: rtl/buck_gate_seq_fsm.sv
module buck_gate_seq_fsm
  import buck_gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic [1:0] en_code,
  input  logic [1:0] pwm_code,
  input  logic       zc_det,
  input  logic       dt_done,
  input  logic       blank_expired,
  output logic       dt_run,
  output logic       dt_wait_ls,
  output logic       blank_run,
  output logic       restart,
  output logic       hs_on,
  output logic       ls_on,
  output logic [3:0] phase_code
);
  phase_e phase_q, phase_d;
  level_e pwm_l, en_l;
  logic   gate_ok;

  assign pwm_l   = fold_level(pwm_code);
  assign en_l    = fold_level(en_code);
  assign gate_ok = supply_ok && (en_l == LVL_HIGH);

  always_comb begin
    phase_d = phase_q;
    if (!supply_ok) begin
      phase_d = PH_SUPPLY_OFF;
    end else if (en_l == LVL_MID) begin
      phase_d = PH_BRAKE;
    end else if (en_l != LVL_HIGH) begin
      phase_d = PH_DISABLED;
    end else begin
      case (phase_q)
        PH_SUPPLY_OFF, PH_DISABLED, PH_BRAKE: phase_d = wait_for(pwm_l);
        PH_WAIT_HS, PH_WAIT_LS, PH_WAIT_EMU: begin
          if (wait_for(pwm_l) != phase_q) begin
            phase_d = wait_for(pwm_l);
          end else if (dt_done) begin
            case (phase_q)
              PH_WAIT_HS: phase_d = PH_HS_ON;
              PH_WAIT_LS: phase_d = PH_LS_ON;
              default:    phase_d = PH_BLANK;
            endcase
          end
        end
        PH_HS_ON: begin
          if (pwm_l != LVL_HIGH) phase_d = wait_for(pwm_l);
        end
        PH_LS_ON: begin
          if (pwm_l == LVL_HIGH)     phase_d = PH_WAIT_HS;
          else if (pwm_l == LVL_MID) phase_d = PH_BLANK;
        end
        PH_BLANK: begin
          if (pwm_l == LVL_HIGH)     phase_d = PH_WAIT_HS;
          else if (pwm_l == LVL_LOW) phase_d = PH_LS_ON;
          else if (blank_expired)    phase_d = PH_WATCH;
        end
        PH_WATCH: begin
          if (pwm_l == LVL_HIGH)     phase_d = PH_WAIT_HS;
          else if (pwm_l == LVL_LOW) phase_d = PH_LS_ON;
          else if (zc_det)           phase_d = PH_EMU_DONE;
        end
        PH_EMU_DONE: begin
          if (pwm_l != LVL_MID) phase_d = wait_for(pwm_l);
        end
        default: phase_d = PH_DISABLED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_DISABLED;
    else     phase_q <= phase_d;
  end

  assign restart    = (phase_d != phase_q);
  assign dt_run     = (phase_q == PH_WAIT_HS) || (phase_q == PH_WAIT_LS) ||
                      (phase_q == PH_WAIT_EMU);
  assign dt_wait_ls = (phase_q == PH_WAIT_HS);
  assign blank_run  = (phase_q == PH_BLANK);

  assign hs_on      = (phase_q == PH_HS_ON);
  assign ls_on      = (phase_q == PH_LS_ON) || (phase_q == PH_BLANK) ||
                      (phase_q == PH_WATCH);
  assign phase_code = phase_q;

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on));

  assert_supply_off_R3: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!hs_on && !ls_on && phase_code == 4'd0));

  assert_brake_low_R4: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && en_code == 2'b01) |=> (!hs_on && !ls_on));

  assert_hs_after_wait_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> ($past(phase_code) == 4'd3));

  assert_blank_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (blank_run && gate_ok && pwm_l == LVL_MID && !blank_expired) |=> ls_on);

  assert_zc_latched_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EMU_DONE && gate_ok && pwm_l == LVL_MID) |=> !ls_on);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int MIN_DT     = 3,
  parameter int DT_TIMEOUT = 20,
  parameter int BLANK_CYC  = 35
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic [1:0] en_code,
  input  logic [1:0] pwm_code,
  input  logic       zc_det,
  input  logic       hs_off_sense,
  input  logic       ls_off_sense,
  output logic       hs_on,
  output logic       ls_on,
  output logic [3:0] phase_code
);
  logic dt_run, dt_wait_ls, dt_done;
  logic blank_run, blank_expired;
  logic restart;
  logic opp_off;

  // The wait before the high side watches the low gate; every other wait watches the high gate.
  assign opp_off = dt_wait_ls ? ls_off_sense : hs_off_sense;

  buck_gate_seq_fsm fsm_i (
    .clk           (clk),
    .rst           (rst),
    .supply_ok     (supply_ok),
    .en_code       (en_code),
    .pwm_code      (pwm_code),
    .zc_det        (zc_det),
    .dt_done       (dt_done),
    .blank_expired (blank_expired),
    .dt_run        (dt_run),
    .dt_wait_ls    (dt_wait_ls),
    .blank_run     (blank_run),
    .restart       (restart),
    .hs_on         (hs_on),
    .ls_on         (ls_on),
    .phase_code    (phase_code)
  );

  buck_gate_seq_deadtime #(.MIN_DT(MIN_DT), .DT_TIMEOUT(DT_TIMEOUT)) deadtime_i (
    .clk     (clk),
    .rst     (rst),
    .run     (dt_run),
    .restart (restart),
    .opp_off (opp_off),
    .done    (dt_done)
  );

  buck_gate_seq_blanking #(.BLANK_CYC(BLANK_CYC)) blanking_i (
    .clk     (clk),
    .rst     (rst),
    .run     (blank_run),
    .restart (restart),
    .expired (blank_expired)
  );
endmodule

// File: tb/buck_gate_seq_tb_top.sv
module buck_gate_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN = 2;
  localparam int TO  = 6;
  localparam int BL  = 4;
  localparam int SETTLE = TO + BL + 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b1;
  logic [1:0] en_code = 2'b10;
  logic [1:0] pwm_code = 2'b10;
  logic       zc_det = 1'b0;
  logic       hs_sense = 1'b1;
  logic       ls_sense = 1'b1;
  logic       hs_on, ls_on;
  logic [3:0] phase_code;

  int  nvec = 0;
  int  nfail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  buck_gate_seq #(.MIN_DT(MIN), .DT_TIMEOUT(TO), .BLANK_CYC(BL)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .supply_ok    (supply_ok),
    .en_code      (en_code),
    .pwm_code     (pwm_code),
    .zc_det       (zc_det),
    .hs_off_sense (hs_sense),
    .ls_off_sense (ls_sense),
    .hs_on        (hs_on),
    .ls_on        (ls_on),
    .phase_code   (phase_code)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; supply_ok = 1'b1; en_code = 2'b10; pwm_code = 2'b00;
    zc_det = 1'b0; hs_sense = 1'b1; ls_sense = 1'b1;
    step();
    rst = 1'b0;
  endtask

  // R5 overlap monitor at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      nvec++;
      if (hs_on && ls_on) begin
        nfail++;
        $display("FAIL R5 overlap: actual hs=%0d ls=%0d expected one low", hs_on, ls_on);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int ph, ehs, els, kexp, fall;

    // R2: reset with a high command present
    step(); step();
    chk("R2 reset phase", phase_code, 1);
    chk("R2 reset hs", hs_on, 0);
    chk("R2 reset ls", ls_on, 0);

    // R1 R3 R4 R13: all supply/enable/command combinations, steady state
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 4; e++) begin
        for (int p = 0; p < 4; p++) begin
          do_reset();
          supply_ok = s[0]; en_code = e[1:0]; pwm_code = p[1:0];
          repeat (SETTLE) step();
          if (s == 0)      begin ph = 0; ehs = 0; els = 0; end
          else if (e == 1) begin ph = 2; ehs = 0; els = 0; end
          else if (e != 2) begin ph = 1; ehs = 0; els = 0; end
          else if (p == 2) begin ph = 4; ehs = 1; els = 0; end
          else if (p == 1) begin ph = 9; ehs = 0; els = 1; end
          else             begin ph = 6; ehs = 0; els = 1; end
          chk("R1 R13 sweep phase", phase_code, ph);
          chk("R3 R4 sweep hs", hs_on, ehs);
          chk("R3 R4 sweep ls", ls_on, els);
        end
      end
    end

    // R6: high-side dead time versus low-gate sense release
    for (int j = 0; j <= TO + 1; j++) begin
      do_reset();
      pwm_code = 2'b10; ls_sense = (j == 0);
      kexp = (MIN + 1 > j + 1) ? MIN + 1 : j + 1;
      if (kexp > TO + 1) kexp = TO + 1;
      for (int k = 1; k <= TO + 2; k++) begin
        step();
        chk("R6 hs rise timing", hs_on, (k >= kexp) ? 1 : 0);
        chk("R6 ls held low", ls_on, 0);
        if (k == j) ls_sense = 1'b1;
      end
    end

    // R7: low-side dead time versus high-gate sense release
    for (int j = 0; j <= TO + 1; j++) begin
      do_reset();
      pwm_code = 2'b00; rst = 1'b1; step(); rst = 1'b0;
      hs_sense = (j == 0);
      kexp = (MIN + 1 > j + 1) ? MIN + 1 : j + 1;
      if (kexp > TO + 1) kexp = TO + 1;
      for (int k = 1; k <= TO + 2; k++) begin
        step();
        chk("R7 ls rise timing", ls_on, (k >= kexp) ? 1 : 0);
        chk("R7 hs held low", hs_on, 0);
        if (k == j) hs_sense = 1'b1;
      end
    end

    // R9 R10: zero-cross assertion swept across blanking
    for (int z = 0; z <= MIN + BL + 3; z++) begin
      do_reset();
      pwm_code = 2'b01; zc_det = (z == 0);
      fall = (z + 1 > MIN + BL + 2) ? z + 1 : MIN + BL + 2;
      for (int k = 1; k <= MIN + BL + 6; k++) begin
        step();
        chk("R9 R10 ls window", ls_on, (k >= MIN + 1 && k < fall) ? 1 : 0);
        chk("R9 hs low", hs_on, 0);
        if (k == z) zc_det = 1'b1;
      end
      zc_det = 1'b0;
      step(); step();
      chk("R10 stays low", ls_on, 0);
      chk("R10 done phase", phase_code, 10);
    end

    // R12: command change during the wait restarts it
    do_reset();
    ls_sense = 1'b0; pwm_code = 2'b10;
    step();
    chk("R12 wait hs", phase_code, 3);
    pwm_code = 2'b00;
    step();
    chk("R12 retarget", phase_code, 5);
    repeat (MIN - 1) step();
    chk("R12 ls not yet", ls_on, 0);
    step();
    chk("R12 ls on", ls_on, 1);

    // R8: mid from high side
    do_reset();
    pwm_code = 2'b10;
    repeat (MIN + 2) step();
    chk("R8 hs on first", hs_on, 1);
    pwm_code = 2'b01;
    step();
    chk("R8 hs drops", hs_on, 0);
    chk("R8 wait phase", phase_code, 7);
    repeat (MIN - 1) step();
    chk("R8 ls not yet", ls_on, 0);
    step();
    chk("R8 ls rises", ls_on, 1);
    chk("R8 blank phase", phase_code, 8);

    // R8 R9: mid from low side goes straight to blanking
    do_reset();
    pwm_code = 2'b00;
    repeat (MIN + 2) step();
    chk("R8 ls on first", phase_code, 6);
    pwm_code = 2'b01; zc_det = 1'b1;
    step();
    chk("R8 direct blank", phase_code, 8);
    chk("R8 ls kept", ls_on, 1);
    repeat (BL) step();
    chk("R9 watch reached", phase_code, 9);
    chk("R9 ls still on", ls_on, 1);
    step();
    chk("R10 zc release", ls_on, 0);

    // R11: low command out of emulation done
    pwm_code = 2'b00;
    step();
    chk("R11 low from done", phase_code, 5);
    repeat (MIN) step();
    chk("R11 ls back", ls_on, 1);
    pwm_code = 2'b01; zc_det = 1'b0;
    step();
    chk("R11 blank again", phase_code, 8);
    repeat (BL) step();
    chk("R11 watch", phase_code, 9);
    pwm_code = 2'b00;
    step();
    chk("R11 low from watch", phase_code, 6);
    chk("R11 ls held", ls_on, 1);
    pwm_code = 2'b01; zc_det = 1'b1;
    step();
    chk("R11 rearmed blank", phase_code, 8);
    repeat (BL + 1) step();
    chk("R11 done", phase_code, 10);
    pwm_code = 2'b10;
    step();
    chk("R11 high from done", phase_code, 3);
    repeat (MIN) step();
    chk("R11 hs on", hs_on, 1);

    // R4 R3 R2: overrides from high-side on
    en_code = 2'b01;
    step();
    chk("R4 brake phase", phase_code, 2);
    chk("R4 brake hs", hs_on, 0);
    en_code = 2'b00;
    step();
    chk("R4 disabled", phase_code, 1);
    en_code = 2'b10;
    step();
    chk("R4 resume wait", phase_code, 3);
    supply_ok = 1'b0;
    step();
    chk("R3 supply off", phase_code, 0);
    supply_ok = 1'b1;
    repeat (MIN + 2) step();
    chk("R3 recover hs", hs_on, 1);
    rst = 1'b1;
    step();
    chk("R2 mid-run reset", phase_code, 1);
    chk("R2 mid-run hs", hs_on, 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule